// File: doc/BRIEF.md
# Chained DMA Channel Sequencer

This block is one DMA channel. A local table holds descriptors. Each descriptor is four 16-bit words: a control/link word, a word count and two base addresses. A start command names the first descriptor. The channel loads that descriptor and moves the requested number of words over a simple request/acknowledge bus. When the block finishes, it either follows the link to another descriptor or stops.

Two families of transfer exist. The one-area modes (single, double, burst) touch only area 1. They read memory, or write memory with data taken from a device input. The area-to-area modes copy each word by reading area 1 and then writing area 2. The mode decides whether each area sits in memory or in IO space. Each area's address can increment, decrement or stay constant.

Software can override chaining at run time. An end-of-transfer pulse is raised either after every block or only after the last one, as the descriptor selects.

Top module: `dma_chain_seq`

## Requirements
- R1: The table is written one word at a time with `tbl_we`. `tbl_sel` picks the word: 0 is the control/link word, 1 the word count, 2 the area 1 base, 3 the area 2 base. The control/link word layout is: bits 15:13 mode, 12:11 area 1 action, 10:9 area 2 action, 8 the always-signal bit, 7 the chain bit, 6 unused, 5:0 the next descriptor number.
- R2: `start` is accepted only when the channel is idle, and it loads descriptor `start_idx`. `busy` is high from the cycle after the start until the final block ends. `bus_req` is never high while `busy` is low.
- R3: In modes 0, 1 and 2, every access goes to area 1 in memory space (`bus_io`=0). Bit 1 of the area 1 action selects a write (1) or a read (0). Bit 0 selects a decrementing (1) or incrementing (0) address. Write data comes from `dev_wdata`. The first access uses the base address.
- R4: In mode 0 (single), `bus_req` drops for one cycle after every acknowledged word. In mode 1 (double), it drops after every second word. In mode 2 (burst), requests continue back to back.
- R5: In modes 4 to 7, each word is read from area 1 and the data read is then written to area 2. Area 1 is in IO space when mode bit 1 is set. Area 2 is in IO space when mode bit 0 is set.
- R6: In area-to-area modes, each area's action works as follows: 01 increments the address, 10 decrements it, 00 and 11 hold it constant. An address steps only after its own access is acknowledged. While a request waits for acknowledge, `bus_addr` and `bus_we` hold steady.
- R7: The word count sets the number of words moved in the block. A count of zero ends the block with no bus access, and end-of-transfer and chaining are still evaluated.
- R8: Mode 3 means the channel is not started. Loading such a descriptor ends the run with no bus access and no end-of-transfer pulse.
- R9: At the end of a block, the channel loads the next descriptor and continues if the chain bit is 1 and chaining is enabled. Otherwise it stops.
- R10: Next descriptor numbers 0x3C to 0x3F end the run after the current block, even when the chain bit is 1.
- R11: `eot` is a one-cycle pulse in the cycle after a block ends. It is raised after every block when the always-signal bit is 1. When that bit is 0, it is raised only if the channel stops after that block.
- R12: Driving `chain_ctl_we` with `chain_ctl_val`=0 suppresses chaining. Driving it with 1 restores chaining as the descriptor defines it. `chain_will` reports the loaded chain bit ANDed with this enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tbl_we | input | 1 | Descriptor table write strobe |
| tbl_idx | input | IDX_W | Descriptor number written |
| tbl_sel | input | 2 | Word within descriptor |
| tbl_wdata | input | 16 | Table write data |
| start | input | 1 | Start command |
| start_idx | input | IDX_W | First descriptor number |
| chain_ctl_we | input | 1 | Chain enable write strobe |
| chain_ctl_val | input | 1 | Chain enable value |
| chain_will | output | 1 | Chaining will be performed |
| busy | output | 1 | Channel active |
| eot | output | 1 | End-of-transfer pulse |
| bus_req | output | 1 | Bus access request |
| bus_we | output | 1 | Access is a write |
| bus_io | output | 1 | Access targets IO space |
| bus_addr | output | ADDR_W | Access address |
| bus_wdata | output | DATA_W | Write data |
| bus_rdata | input | DATA_W | Read data, valid with acknowledge |
| bus_ack | input | 1 | Access acknowledge |
| dev_wdata | input | DATA_W | Device data for one-area writes |

## Verification
The assertions check, on every cycle, the following rules:
- no request outside a run;
- address and direction held while a request waits;
- the gap after each single-mode word;
- an area-to-area write that follows every read with the data just read;
- the one-cycle shape of `eot`.

Only the directed scenarios can show some properties. These are address sequences, word counts, IO/memory selection per mode, following of chain links, stop codes, the run-time chain override, and how many `eot` pulses a chain produces.

// File: rtl/dmaseq_pkg.sv
package dmaseq_pkg;

   localparam int TBL_W      = 16;
   localparam int LINK_IDX_W = 6;
   localparam int SEL_W      = 2;
   localparam int NUM_WORDS  = 4;

   typedef enum logic [2:0] {
      MD_SINGLE = 3'd0,
      MD_DOUBLE = 3'd1,
      MD_BURST  = 3'd2,
      MD_OFF    = 3'd3,
      MD_MM     = 3'd4,
      MD_MIO    = 3'd5,
      MD_IOM    = 3'd6,
      MD_IOIO   = 3'd7
   } xfer_mode_e;

   typedef struct packed {
      logic [2:0]            mode;
      logic [1:0]            a1m;
      logic [1:0]            a2m;
      logic                  seot;
      logic                  chain;
      logic                  spare;
      logic [LINK_IDX_W-1:0] nxt;
   } link_word_t;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_FETCH,
      ST_RD1,
      ST_WR2,
      ST_GAP,
      ST_BLKEND
   } seq_state_e;

   // step codes: 2'b01 up, 2'b10 down, others hold
   function automatic logic [1:0] area1_step(input link_word_t lw);
      if (lw.mode[2]) return lw.a1m;
      return lw.a1m[0] ? 2'b10 : 2'b01;
   endfunction

   function automatic logic [1:0] area2_step(input link_word_t lw);
      return lw.mode[2] ? lw.a2m : 2'b00;
   endfunction

   function automatic logic [1:0] group_words(input link_word_t lw);
      case (lw.mode)
         MD_SINGLE: return 2'd1;
         MD_DOUBLE: return 2'd2;
         default:   return 2'd0;
      endcase
   endfunction

endpackage

// File: rtl/dmaseq_desc_table.sv
module dmaseq_desc_table
   import dmaseq_pkg::*;
#(
   parameter int IDX_W  = 6,
   parameter int WORD_W = TBL_W
)(
   input  logic              clk,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [SEL_W-1:0]  wr_sel,
   input  logic [WORD_W-1:0] wr_data,
   input  logic [IDX_W-1:0]  rd_idx,
   output logic [WORD_W-1:0] rd_link,
   output logic [WORD_W-1:0] rd_len,
   output logic [WORD_W-1:0] rd_base1,
   output logic [WORD_W-1:0] rd_base2
);

   localparam int DEPTH = 1 << IDX_W;

   logic [NUM_WORDS-1:0][WORD_W-1:0] rd_word;

   if (IDX_W < 1 || IDX_W > LINK_IDX_W) begin : g_bad_idx
      $error("dmaseq_desc_table: IDX_W out of range");
   end

   for (genvar s = 0; s < NUM_WORDS; s++) begin : g_bank
      logic [WORD_W-1:0] cells [DEPTH];

      always_ff @(posedge clk) begin
         if (wr_en && wr_sel == SEL_W'(s))
            cells[wr_idx] <= wr_data;
      end

      assign rd_word[s] = cells[rd_idx];
   end

   assign rd_link  = rd_word[0];
   assign rd_len   = rd_word[1];
   assign rd_base1 = rd_word[2];
   assign rd_base2 = rd_word[3];

endmodule

// File: rtl/dmaseq_addr_step.sv
module dmaseq_addr_step #(
   parameter int ADDR_W = 16
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [ADDR_W-1:0] base,
   input  logic              adv,
   input  logic [1:0]        step_code,
   output logic [ADDR_W-1:0] addr
);

   if (ADDR_W < 2) begin : g_bad_aw
      $error("dmaseq_addr_step: ADDR_W too small");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr <= '0;
      end else if (load) begin
         addr <= base;
      end else if (adv) begin
         case (step_code)
            2'b01:   addr <= addr + ADDR_W'(1);
            2'b10:   addr <= addr - ADDR_W'(1);
            default: addr <= addr;
         endcase
      end
   end

endmodule

// File: rtl/dmaseq_pacer.sv
module dmaseq_pacer #(
   parameter int GRP_W = 2
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             word_done,
   input  logic [GRP_W-1:0] group_len,
   output logic             gap_due
);

   logic [GRP_W-1:0] cnt_q;

   if (GRP_W < 2) begin : g_bad_grp
      $error("dmaseq_pacer: GRP_W must hold a group of two");
   end

   assign gap_due = word_done && (group_len != '0) &&
                    (cnt_q == group_len - GRP_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         cnt_q <= '0;
      else if (clear)     cnt_q <= '0;
      else if (word_done) cnt_q <= gap_due ? '0 : cnt_q + GRP_W'(1);
   end

endmodule

// File: rtl/dma_chain_seq.sv
module dma_chain_seq
   import dmaseq_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int DATA_W = 16,
   parameter int LEN_W  = 16,
   parameter int IDX_W  = 6
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tbl_we,
   input  logic [IDX_W-1:0]  tbl_idx,
   input  logic [1:0]        tbl_sel,
   input  logic [15:0]       tbl_wdata,
   input  logic              start,
   input  logic [IDX_W-1:0]  start_idx,
   input  logic              chain_ctl_we,
   input  logic              chain_ctl_val,
   output logic              chain_will,
   output logic              busy,
   output logic              eot,
   output logic              bus_req,
   output logic              bus_we,
   output logic              bus_io,
   output logic [ADDR_W-1:0] bus_addr,
   output logic [DATA_W-1:0] bus_wdata,
   input  logic [DATA_W-1:0] bus_rdata,
   input  logic              bus_ack,
   input  logic [DATA_W-1:0] dev_wdata
);

   localparam logic [LINK_IDX_W-1:0] STOP_BASE = LINK_IDX_W'(6'h3C);

   if (ADDR_W > TBL_W || LEN_W > TBL_W) begin : g_bad_w
      $error("dma_chain_seq: ADDR_W and LEN_W must fit a table word");
   end
   if (IDX_W > LINK_IDX_W || IDX_W < 3) begin : g_bad_idx
      $error("dma_chain_seq: IDX_W out of range");
   end

   seq_state_e         state_q;
   link_word_t         lk_q, tbl_lk;
   logic [IDX_W-1:0]   idx_q;
   logic [LEN_W-1:0]   cnt_q;
   logic [DATA_W-1:0]  hold_q;
   logic               allow_q;
   logic               eot_q;
   logic [TBL_W-1:0]   t_link, t_len, t_b1, t_b2;
   logic [ADDR_W-1:0]  a1_addr, a2_addr;
   logic               a2a, last_word, rd_done, wr_done, gap_due;
   logic               chain_go, is_fetch;

   dmaseq_desc_table #(.IDX_W(IDX_W), .WORD_W(TBL_W)) table_i (
      .clk      (clk),
      .wr_en    (tbl_we),
      .wr_idx   (tbl_idx),
      .wr_sel   (tbl_sel),
      .wr_data  (tbl_wdata),
      .rd_idx   (idx_q),
      .rd_link  (t_link),
      .rd_len   (t_len),
      .rd_base1 (t_b1),
      .rd_base2 (t_b2)
   );

   assign tbl_lk    = link_word_t'(t_link);
   assign is_fetch  = (state_q == ST_FETCH);
   assign a2a       = lk_q.mode[2];
   assign last_word = (cnt_q == LEN_W'(1));
   assign rd_done   = (state_q == ST_RD1) && bus_ack;
   assign wr_done   = (state_q == ST_WR2) && bus_ack;
   assign chain_go  = lk_q.chain && allow_q && (lk_q.nxt < STOP_BASE);

   dmaseq_addr_step #(.ADDR_W(ADDR_W)) step1_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (is_fetch),
      .base      (t_b1[ADDR_W-1:0]),
      .adv       (rd_done),
      .step_code (area1_step(lk_q)),
      .addr      (a1_addr)
   );

   dmaseq_addr_step #(.ADDR_W(ADDR_W)) step2_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (is_fetch),
      .base      (t_b2[ADDR_W-1:0]),
      .adv       (wr_done),
      .step_code (area2_step(lk_q)),
      .addr      (a2_addr)
   );

   dmaseq_pacer #(.GRP_W(2)) pacer_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .clear     (is_fetch),
      .word_done (rd_done && !a2a),
      .group_len (group_words(lk_q)),
      .gap_due   (gap_due)
   );

   // sequencer
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         lk_q    <= '0;
         idx_q   <= '0;
         cnt_q   <= '0;
         hold_q  <= '0;
         eot_q   <= 1'b0;
      end else begin
         eot_q <= 1'b0;
         case (state_q)
            ST_IDLE: begin
               if (start) begin
                  idx_q   <= start_idx;
                  state_q <= ST_FETCH;
               end
            end
            ST_FETCH: begin
               lk_q  <= tbl_lk;
               cnt_q <= t_len[LEN_W-1:0];
               if (tbl_lk.mode == MD_OFF)          state_q <= ST_IDLE;
               else if (t_len[LEN_W-1:0] == '0)    state_q <= ST_BLKEND;
               else                                state_q <= ST_RD1;
            end
            ST_RD1: begin
               if (bus_ack) begin
                  if (a2a) begin
                     hold_q  <= bus_rdata;
                     state_q <= ST_WR2;
                  end else begin
                     cnt_q <= cnt_q - LEN_W'(1);
                     if (last_word)    state_q <= ST_BLKEND;
                     else if (gap_due) state_q <= ST_GAP;
                  end
               end
            end
            ST_WR2: begin
               if (bus_ack) begin
                  cnt_q   <= cnt_q - LEN_W'(1);
                  state_q <= last_word ? ST_BLKEND : ST_RD1;
               end
            end
            ST_GAP: state_q <= ST_RD1;
            ST_BLKEND: begin
               eot_q <= lk_q.seot || !chain_go;
               if (chain_go) begin
                  idx_q   <= lk_q.nxt[IDX_W-1:0];
                  state_q <= ST_FETCH;
               end else begin
                  state_q <= ST_IDLE;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            allow_q <= 1'b1;
      else if (chain_ctl_we) allow_q <= chain_ctl_val;
   end

   assign chain_will = lk_q.chain && allow_q;
   assign busy       = (state_q != ST_IDLE);
   assign eot        = eot_q;
   assign bus_req    = (state_q == ST_RD1) || (state_q == ST_WR2);
   assign bus_addr   = (state_q == ST_WR2) ? a2_addr : a1_addr;
   assign bus_we     = (state_q == ST_WR2) ? 1'b1 : (!a2a && lk_q.a1m[1]);
   assign bus_io     = (state_q == ST_WR2) ? lk_q.mode[0] : (a2a && lk_q.mode[1]);
   assign bus_wdata  = (state_q == ST_WR2) ? hold_q : dev_wdata;

   // R2
   idle_no_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !bus_req);

   // R6
   addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_req && !bus_ack |=> bus_req && $stable(bus_addr) && $stable(bus_we));

   // R4
   single_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_req && bus_ack && lk_q.mode == MD_SINGLE |=> !bus_req);

   // R5
   copy_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_req && bus_ack && !bus_we && a2a |=>
         bus_req && bus_we && bus_wdata == $past(bus_rdata));

   // R11
   eot_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      eot |=> !eot);

endmodule

// File: tb/dma_chain_seq_tb.sv
module dma_chain_seq_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tbl_we = 1'b0;
   logic [5:0]  tbl_idx = '0;
   logic [1:0]  tbl_sel = '0;
   logic [15:0] tbl_wdata = '0;
   logic        start = 1'b0;
   logic [5:0]  start_idx = '0;
   logic        chain_ctl_we = 1'b0;
   logic        chain_ctl_val = 1'b0;
   logic        chain_will, busy, eot, bus_req, bus_we, bus_io;
   logic [15:0] bus_addr, bus_wdata, bus_rdata;
   logic        bus_ack;
   logic [15:0] dev_wdata = 16'hBEEF;

   int n_chk = 0;
   int n_fail = 0;
   int cyc = 0;
   int log_n = 0;
   int eot_total = 0;
   logic [15:0] log_addr [128];
   logic [15:0] log_data [128];
   logic        log_we   [128];
   logic        log_io   [128];
   int          log_cyc  [128];

   always #5 clk = ~clk;

   dma_chain_seq dut_i (
      .clk(clk), .rst_n(rst_n),
      .tbl_we(tbl_we), .tbl_idx(tbl_idx), .tbl_sel(tbl_sel), .tbl_wdata(tbl_wdata),
      .start(start), .start_idx(start_idx),
      .chain_ctl_we(chain_ctl_we), .chain_ctl_val(chain_ctl_val),
      .chain_will(chain_will), .busy(busy), .eot(eot),
      .bus_req(bus_req), .bus_we(bus_we), .bus_io(bus_io),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .bus_ack(bus_ack), .dev_wdata(dev_wdata)
   );

   assign bus_rdata = 16'hA000 ^ bus_addr;

   // bus responder and logger
   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (!rst_n) begin
         bus_ack   <= 1'b0;
         log_n     <= 0;
         eot_total <= 0;
      end else begin
         bus_ack <= bus_req && !bus_ack;
         if (bus_req && bus_ack) begin
            log_addr[log_n % 128] <= bus_addr;
            log_data[log_n % 128] <= bus_we ? bus_wdata : bus_rdata;
            log_we[log_n % 128]   <= bus_we;
            log_io[log_n % 128]   <= bus_io;
            log_cyc[log_n % 128]  <= cyc;
            log_n <= log_n + 1;
         end
         if (eot) eot_total <= eot_total + 1;
      end
   end

   task automatic chk(input bit ok, input string rq, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
      end
   endtask

   function automatic logic [15:0] mk_link(input logic [2:0] md, input logic [1:0] a1,
         input logic [1:0] a2, input logic se, input logic ch, input logic [5:0] nx);
      return {md, a1, a2, se, ch, 1'b0, nx};
   endfunction

   task automatic put_word(input logic [5:0] idx, input logic [1:0] sel, input logic [15:0] d);
      @(negedge clk);
      tbl_we = 1'b1; tbl_idx = idx; tbl_sel = sel; tbl_wdata = d;
      @(negedge clk);
      tbl_we = 1'b0;
   endtask

   // R1: word 0 link, 1 count, 2 base 1, 3 base 2
   task automatic put_desc(input logic [5:0] idx, input logic [15:0] lk,
         input logic [15:0] len, input logic [15:0] b1, input logic [15:0] b2);
      put_word(idx, 2'd0, lk);
      put_word(idx, 2'd1, len);
      put_word(idx, 2'd2, b1);
      put_word(idx, 2'd3, b2);
   endtask

   int lbase, ebase;

   task automatic run_desc(input logic [5:0] idx);
      int t;
      lbase = log_n;
      ebase = eot_total;
      @(negedge clk);
      start = 1'b1; start_idx = idx;
      @(negedge clk);
      start = 1'b0;
      chk(busy == 1'b1, "R2 busy after start", busy, 1);
      t = 0;
      while (busy && t < 5000) begin
         @(negedge clk);
         t++;
      end
      chk(busy == 1'b0, "R2 busy falls at end", busy, 0);
      @(negedge clk);
   endtask

   task automatic t_reset;
      chk(busy == 1'b0, "R2 reset busy", busy, 0);
      chk(bus_req == 1'b0, "R2 reset bus_req", bus_req, 0);
      chk(eot == 1'b0, "R11 reset eot", eot, 0);
      chk(chain_will == 1'b0, "R12 reset chain_will", chain_will, 0);
   endtask

   task automatic t_single_read;
      put_desc(6'd1, mk_link(3'd0, 2'b00, 2'b00, 1'b0, 1'b0, 6'd0), 16'd3, 16'h0010, 16'h0);
      run_desc(6'd1);
      chk(log_n - lbase == 3, "R7 single word count", log_n - lbase, 3);
      for (int i = 0; i < 3; i++) begin
         chk(log_addr[lbase+i] == 16'h0010 + 16'(i), "R1 R3 single read addr",
             log_addr[lbase+i], 16'h0010 + i);
         chk(!log_we[lbase+i] && !log_io[lbase+i], "R3 single read memory",
             {log_we[lbase+i], log_io[lbase+i]}, 0);
      end
      for (int i = 0; i < 2; i++)
         chk(log_cyc[lbase+i+1] - log_cyc[lbase+i] == 3, "R4 single spacing",
             log_cyc[lbase+i+1] - log_cyc[lbase+i], 3);
      chk(eot_total - ebase == 1, "R11 eot single block", eot_total - ebase, 1);
   endtask

   task automatic t_burst_write;
      put_desc(6'd2, mk_link(3'd2, 2'b11, 2'b00, 1'b0, 1'b0, 6'd0), 16'd4, 16'h0040, 16'h0);
      run_desc(6'd2);
      chk(log_n - lbase == 4, "R7 burst count", log_n - lbase, 4);
      for (int i = 0; i < 4; i++) begin
         chk(log_addr[lbase+i] == 16'h0040 - 16'(i), "R3 write decrement addr",
             log_addr[lbase+i], 16'h0040 - i);
         chk(log_we[lbase+i] && log_data[lbase+i] == 16'hBEEF, "R3 write data",
             log_data[lbase+i], 16'hBEEF);
      end
      for (int i = 0; i < 3; i++)
         chk(log_cyc[lbase+i+1] - log_cyc[lbase+i] == 2, "R4 burst spacing",
             log_cyc[lbase+i+1] - log_cyc[lbase+i], 2);
   endtask

   task automatic t_double;
      put_desc(6'd3, mk_link(3'd1, 2'b00, 2'b00, 1'b0, 1'b0, 6'd0), 16'd4, 16'h0000, 16'h0);
      run_desc(6'd3);
      chk(log_n - lbase == 4, "R7 double count", log_n - lbase, 4);
      chk(log_cyc[lbase+1] - log_cyc[lbase] == 2, "R4 double pair",
          log_cyc[lbase+1] - log_cyc[lbase], 2);
      chk(log_cyc[lbase+2] - log_cyc[lbase+1] == 3, "R4 double gap",
          log_cyc[lbase+2] - log_cyc[lbase+1], 3);
      chk(log_cyc[lbase+3] - log_cyc[lbase+2] == 2, "R4 double pair 2",
          log_cyc[lbase+3] - log_cyc[lbase+2], 2);
   endtask

   task automatic t_area_copy;
      // memory to IO, area 1 up, area 2 down
      put_desc(6'd4, mk_link(3'd5, 2'b01, 2'b10, 1'b0, 1'b0, 6'd0), 16'd3, 16'h0020, 16'h0080);
      run_desc(6'd4);
      chk(log_n - lbase == 6, "R5 copy access count", log_n - lbase, 6);
      for (int k = 0; k < 3; k++) begin
         chk(log_addr[lbase+2*k] == 16'h0020 + 16'(k) && !log_we[lbase+2*k] && !log_io[lbase+2*k],
             "R5 R6 area1 read", log_addr[lbase+2*k], 16'h0020 + k);
         chk(log_addr[lbase+2*k+1] == 16'h0080 - 16'(k) && log_we[lbase+2*k+1] && log_io[lbase+2*k+1],
             "R5 R6 area2 write", log_addr[lbase+2*k+1], 16'h0080 - k);
         chk(log_data[lbase+2*k+1] == (16'hA000 ^ (16'h0020 + 16'(k))), "R5 copied data",
             log_data[lbase+2*k+1], 16'hA000 ^ (16'h0020 + k));
      end
      // IO to IO, both constant (00 and 11)
      put_desc(6'd14, mk_link(3'd7, 2'b00, 2'b11, 1'b0, 1'b0, 6'd0), 16'd2, 16'h0030, 16'h0090);
      run_desc(6'd14);
      chk(log_n - lbase == 4, "R5 io copy count", log_n - lbase, 4);
      for (int i = 0; i < 4; i++)
         chk(log_addr[lbase+i] == ((i % 2 == 0) ? 16'h0030 : 16'h0090) && log_io[lbase+i],
             "R6 constant io addr", log_addr[lbase+i], (i % 2 == 0) ? 16'h30 : 16'h90);
   endtask

   task automatic t_zero_and_off;
      put_desc(6'd10, mk_link(3'd0, 2'b00, 2'b00, 1'b0, 1'b0, 6'd0), 16'd0, 16'h0011, 16'h0);
      run_desc(6'd10);
      chk(log_n == lbase, "R7 zero length no access", log_n - lbase, 0);
      chk(eot_total - ebase == 1, "R7 zero length eot", eot_total - ebase, 1);
      put_desc(6'd12, mk_link(3'd0, 2'b00, 2'b00, 1'b0, 1'b1, 6'd13), 16'd0, 16'h0, 16'h0);
      put_desc(6'd13, mk_link(3'd2, 2'b00, 2'b00, 1'b1, 1'b0, 6'd0), 16'd0, 16'h0, 16'h0);
      run_desc(6'd12);
      chk(eot_total - ebase == 1, "R7 R9 zero length chain eot", eot_total - ebase, 1);
      put_desc(6'd11, mk_link(3'd3, 2'b00, 2'b00, 1'b1, 1'b0, 6'd0), 16'd2, 16'h0012, 16'h0);
      run_desc(6'd11);
      chk(log_n == lbase, "R8 not started no access", log_n - lbase, 0);
      chk(eot_total == ebase, "R8 not started no eot", eot_total - ebase, 0);
   endtask

   task automatic t_chain;
      put_desc(6'd5, mk_link(3'd0, 2'b00, 2'b00, 1'b0, 1'b1, 6'd6), 16'd1, 16'h0050, 16'h0);
      put_desc(6'd6, mk_link(3'd2, 2'b00, 2'b00, 1'b0, 1'b0, 6'd0), 16'd2, 16'h0060, 16'h0);
      run_desc(6'd5);
      chk(log_n - lbase == 3, "R9 chained count", log_n - lbase, 3);
      chk(log_addr[lbase+1] == 16'h0060 && log_addr[lbase+2] == 16'h0061, "R9 next descriptor",
          log_addr[lbase+1], 16'h0060);
      chk(eot_total - ebase == 1, "R11 eot only at last", eot_total - ebase, 1);
      put_desc(6'd7, mk_link(3'd0, 2'b00, 2'b00, 1'b1, 1'b1, 6'd8), 16'd1, 16'h0070, 16'h0);
      put_desc(6'd8, mk_link(3'd0, 2'b00, 2'b00, 1'b1, 1'b0, 6'd0), 16'd1, 16'h0071, 16'h0);
      run_desc(6'd7);
      chk(eot_total - ebase == 2, "R11 eot every block", eot_total - ebase, 2);
      put_desc(6'd9, mk_link(3'd0, 2'b00, 2'b00, 1'b0, 1'b1, 6'h3D), 16'd1, 16'h0072, 16'h0);
      run_desc(6'd9);
      chk(log_n - lbase == 1, "R10 stop code count", log_n - lbase, 1);
      chk(eot_total - ebase == 1, "R10 stop code eot", eot_total - ebase, 1);
   endtask

   task automatic t_override;
      @(negedge clk);
      chain_ctl_we = 1'b1; chain_ctl_val = 1'b0;
      @(negedge clk);
      chain_ctl_we = 1'b0;
      run_desc(6'd5);
      chk(log_n - lbase == 1, "R12 suppressed chain count", log_n - lbase, 1);
      chk(chain_will == 1'b0, "R12 chain_will suppressed", chain_will, 0);
      @(negedge clk);
      chain_ctl_we = 1'b1; chain_ctl_val = 1'b1;
      @(negedge clk);
      chain_ctl_we = 1'b0;
      chk(chain_will == 1'b1, "R12 chain_will restored", chain_will, 1);
      run_desc(6'd5);
      chk(log_n - lbase == 3, "R12 restored chain count", log_n - lbase, 3);
   endtask

   task automatic t_start_busy;
      // R2: a second start while busy is ignored
      lbase = log_n;
      @(negedge clk);
      start = 1'b1; start_idx = 6'd2;
      @(negedge clk);
      start_idx = 6'd1;
      @(negedge clk);
      start = 1'b0;
      while (busy) @(negedge clk);
      @(negedge clk);
      chk(log_n - lbase == 4, "R2 start ignored while busy", log_n - lbase, 4);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_single_read();
      t_burst_write();
      t_double();
      t_area_copy();
      t_zero_and_off();
      t_chain();
      t_override();
      t_start_busy();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule